// File: doc/BRIEF.md
# MMU Fault Status Capture Unit

This block sits beside an address translator and keeps the record that software inspects after a translation or access fault. Each fault event carries a table level, an access type, a fault type, an address-valid flag, the faulting virtual address, eight bus-error bits and the address space identifier (ASI) of the access. The block stores the event in a fault status register and, when the address is valid, in a fault address register. One cycle after the event it decides whether to raise a trap request.

A separate asynchronous fault path records bus errors that arrive outside the translation flow, together with a 36-bit physical address. A simple register port reaches the control, context table pointer, context, fault and asynchronous fault registers. The port reads combinationally and writes on the clock edge. Reading a status register clears it.

Top module: `mmu_fault_capture`

## Requirements
- R1: After reset, trap_req is low and every register reads zero, except bits 31:28 and 27:24 of the control register. Those bits hold the IMPL_ID and VERS_ID parameters.
- R2: In the control register, bits 23:8 (implementation field), bit 7 (store ordering), bit 1 (no-fault) and bit 0 (enable) are written by software. Bits 6:2 always read zero. Writes to bits 31:24 have no effect.
- R3: In the context table pointer, bits 31:2 are writable and bits 1:0 read zero. In the context register, the low CTX_W bits are writable and the rest read zero.
- R4: A fault event updates the status register one clock later. The status value is then {14'b0, bus_err[17:10], level[9:8], access[7:5], type[4:2], addr_ok[1], overwrite[0]}. Access codes 0 to 7 mean: user/supervisor load, user/supervisor fetch, user/supervisor data store, user/supervisor instruction store. Fault codes 0 to 7 mean: none, invalid address, protection, privilege, translation, bus access, internal, reserved. All codes are stored unchanged.
- R5: The fault address register takes the event address only when addr_ok is 1. Otherwise it keeps its value.
- R6: The overwrite bit (bit 0) is set when an event arrives while an earlier captured fault has not yet been read.
- R7: A read of the fault status register returns the current value. From the next cycle the register reads zero, including the overwrite bit.
- R8: If an event arrives in the same cycle as a status read, the status holds the new event with overwrite 0.
- R9: trap_req pulses high for one cycle, one cycle after each event. It does so when no-fault is 0, or when the event ASI equals 9. Otherwise it stays low, while the registers still capture the event.
- R10: An asynchronous event sets the asynchronous status register one clock later to UCE in bit 12, timeout in bit 11, bus error in bit 10, physical address bits 35:32 in bits 7:4, and 1 in bit 0. The asynchronous address register takes address bits 31:0. Reading the asynchronous status clears it the next cycle, unless a new event arrives in that cycle; the new event then wins.
- R11: Writes to the four fault registers have no effect. Reads of unmapped offsets return zero.
- R12: Register offsets are: control 0x000, context table pointer 0x100, context 0x200, fault status 0x300, fault address 0x400, asynchronous status 0x500, asynchronous address 0x600.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_valid | input | 1 | Translation fault event strobe |
| flt_level | input | 2 | Table level of the fault |
| flt_access | input | 3 | Access type code |
| flt_type | input | 3 | Fault type code |
| flt_addr_ok | input | 1 | Event address is valid |
| flt_addr | input | 32 | Faulting virtual address |
| flt_bus_err | input | 8 | Bus error bits |
| flt_asi | input | 8 | ASI of the faulting access |
| afl_valid | input | 1 | Asynchronous fault strobe |
| afl_uce | input | 1 | Uncorrectable error |
| afl_bto | input | 1 | Bus timeout |
| afl_berr | input | 1 | Generic bus error |
| afl_paddr | input | 36 | Asynchronous fault physical address |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 write, 0 read |
| reg_addr | input | 12 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero when no read |
| trap_req | output | 1 | Trap request pulse |

## Verification
The assertions assume that flt_valid and the register strobes are held low during reset. They also assume that a status read and an event in the same cycle are legal and resolve in favour of the event. The stimulus drives inputs only at falling edges. It mixes random events, random ASIs and random register accesses, including unmapped offsets and writes to read-only registers. It also toggles the no-fault bit at random through control writes. Directed sequences produce back-to-back faults, same-cycle read and event pairs, and the ASI 9 exemption.

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture #(
  parameter logic [3:0] IMPL_ID  = 4'h1,
  parameter logic [3:0] VERS_ID  = 4'h0,
  parameter int         CTX_W    = 8,
  parameter logic [7:0] TRAP_ASI = 8'h09
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        flt_valid,
  input  logic [1:0]  flt_level,
  input  logic [2:0]  flt_access,
  input  logic [2:0]  flt_type,
  input  logic        flt_addr_ok,
  input  logic [31:0] flt_addr,
  input  logic [7:0]  flt_bus_err,
  input  logic [7:0]  flt_asi,
  input  logic        afl_valid,
  input  logic        afl_uce,
  input  logic        afl_bto,
  input  logic        afl_berr,
  input  logic [35:0] afl_paddr,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        trap_req
);
  localparam logic [11:0] OFF_CTL  = 12'h000;
  localparam logic [11:0] OFF_CTP  = 12'h100;
  localparam logic [11:0] OFF_CTX  = 12'h200;
  localparam logic [11:0] OFF_FSR  = 12'h300;
  localparam logic [11:0] OFF_FAR  = 12'h400;
  localparam logic [11:0] OFF_AFSR = 12'h500;
  localparam logic [11:0] OFF_AFAR = 12'h600;
  localparam logic [23:0] CTL_WMASK = 24'hFFFF83;

  logic [23:0]      ctl_q;
  logic [29:0]      ctp_q;
  logic [CTX_W-1:0] ctx_q;
  logic [17:0]      fsr_q;
  logic             fsr_full;
  logic [31:0]      far_q;
  logic [12:0]      afsr_q;
  logic [31:0]      afar_q;
  logic             trap_q;

  wire rd     = reg_sel & ~reg_wr;
  wire wr     = reg_sel & reg_wr;
  wire rd_fsr = rd & (reg_addr == OFF_FSR);
  wire rd_afs = rd & (reg_addr == OFF_AFSR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      ctp_q <= '0;
      ctx_q <= '0;
    end else if (wr) begin
      case (reg_addr)
        OFF_CTL: ctl_q <= reg_wdata[23:0] & CTL_WMASK;
        OFF_CTP: ctp_q <= reg_wdata[31:2];
        OFF_CTX: ctx_q <= reg_wdata[CTX_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsr_q    <= '0;
      fsr_full <= 1'b0;
      far_q    <= '0;
      trap_q   <= 1'b0;
    end else begin
      trap_q <= flt_valid & (~ctl_q[1] | (flt_asi == TRAP_ASI));
      if (flt_valid) begin
        fsr_q    <= {flt_bus_err, flt_level, flt_access, flt_type, flt_addr_ok,
                     fsr_full & ~rd_fsr};
        fsr_full <= 1'b1;
        if (flt_addr_ok) far_q <= flt_addr;
      end else if (rd_fsr) begin
        fsr_q    <= '0;
        fsr_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      afsr_q <= '0;
      afar_q <= '0;
    end else if (afl_valid) begin
      afsr_q <= {afl_uce, afl_bto, afl_berr, 2'b00, afl_paddr[35:32], 3'b000, 1'b1};
      afar_q <= afl_paddr[31:0];
    end else if (rd_afs) begin
      afsr_q <= '0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (rd) begin
      case (reg_addr)
        OFF_CTL:  reg_rdata = {IMPL_ID, VERS_ID, ctl_q};
        OFF_CTP:  reg_rdata = {ctp_q, 2'b00};
        OFF_CTX:  reg_rdata = {{(32-CTX_W){1'b0}}, ctx_q};
        OFF_FSR:  reg_rdata = {14'd0, fsr_q};
        OFF_FAR:  reg_rdata = far_q;
        OFF_AFSR: reg_rdata = {19'd0, afsr_q};
        OFF_AFAR: reg_rdata = afar_q;
        default:  reg_rdata = '0;
      endcase
    end
  end

  assign trap_req = trap_q;
endmodule

// File: rtl/mmu_fault_capture_chk.sv
module mmu_fault_capture_chk #(
  parameter logic [3:0] IMPL_ID  = 4'h1,
  parameter logic [3:0] VERS_ID  = 4'h0,
  parameter logic [7:0] TRAP_ASI = 8'h09
) (
  input logic        clk,
  input logic        rst_n,
  input logic        flt_valid,
  input logic        flt_addr_ok,
  input logic [7:0]  flt_asi,
  input logic        reg_sel,
  input logic        reg_wr,
  input logic [11:0] reg_addr,
  input logic [31:0] reg_rdata,
  input logic        trap_req,
  input logic        nf,
  input logic [17:0] fsr,
  input logic        full,
  input logic [31:0] far
);
  wire rd_fsr = reg_sel & ~reg_wr & (reg_addr == 12'h300);

  a_r9_trap_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> $past(flt_valid));

  a_r9_nofault_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && nf && flt_asi != TRAP_ASI) |=> !trap_req);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fsr && !flt_valid) |=> (fsr == 18'd0));

  a_r6_overwrite_set: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && full && !rd_fsr) |=> fsr[0]);

  a_r8_read_and_event: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && rd_fsr) |=> !fsr[0]);

  a_r5_far_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_valid && !flt_addr_ok) |=> $stable(far));

  a_r2_ident_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && !reg_wr && reg_addr == 12'h000) |-> (reg_rdata[31:24] == {IMPL_ID, VERS_ID}));
endmodule

bind mmu_fault_capture mmu_fault_capture_chk #(
  .IMPL_ID(IMPL_ID), .VERS_ID(VERS_ID), .TRAP_ASI(TRAP_ASI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_addr_ok(flt_addr_ok),
  .flt_asi(flt_asi), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .trap_req(trap_req), .nf(ctl_q[1]), .fsr(fsr_q),
  .full(fsr_full), .far(far_q)
);

// File: tb/mmu_fault_capture_bench.sv
module mmu_fault_capture_bench;
  localparam int CTX_W = 8;
  localparam logic [3:0] IMPL = 4'h1, VERS = 4'h0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flt_valid, flt_addr_ok, afl_valid, afl_uce, afl_bto, afl_berr;
  logic [1:0]  flt_level;
  logic [2:0]  flt_access, flt_type;
  logic [31:0] flt_addr, reg_wdata, reg_rdata;
  logic [7:0]  flt_bus_err, flt_asi;
  logic [35:0] afl_paddr;
  logic        reg_sel, reg_wr, trap_req;
  logic [11:0] reg_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] m_ctl, m_ctp, m_ctx, m_fsr, m_far, m_afsr, m_afar;
  logic        m_full, m_trap;

  always #10 clk = ~clk;

  mmu_fault_capture #(.IMPL_ID(IMPL), .VERS_ID(VERS), .CTX_W(CTX_W)) u_mmu_fault_capture (
    .clk(clk), .rst_n(rst_n), .flt_valid(flt_valid), .flt_level(flt_level),
    .flt_access(flt_access), .flt_type(flt_type), .flt_addr_ok(flt_addr_ok),
    .flt_addr(flt_addr), .flt_bus_err(flt_bus_err), .flt_asi(flt_asi),
    .afl_valid(afl_valid), .afl_uce(afl_uce), .afl_bto(afl_bto), .afl_berr(afl_berr),
    .afl_paddr(afl_paddr), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trap_req(trap_req));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h000: return {IMPL, VERS, m_ctl[23:0]};
      12'h100: return m_ctp;
      12'h200: return m_ctx;
      12'h300: return m_fsr;
      12'h400: return m_far;
      12'h500: return m_afsr;
      12'h600: return m_afar;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_step();
    logic rdf, rda;
    rdf = reg_sel && !reg_wr && reg_addr == 12'h300;
    rda = reg_sel && !reg_wr && reg_addr == 12'h500;
    m_trap = flt_valid && (!m_ctl[1] || flt_asi == 8'h09);
    if (flt_valid) begin
      m_fsr = {14'd0, flt_bus_err, flt_level, flt_access, flt_type, flt_addr_ok, m_full && !rdf};
      m_full = 1'b1;
      if (flt_addr_ok) m_far = flt_addr;
    end else if (rdf) begin
      m_fsr = 0; m_full = 1'b0;
    end
    if (afl_valid) begin
      m_afsr = {19'd0, afl_uce, afl_bto, afl_berr, 2'b00, afl_paddr[35:32], 4'b0001};
      m_afar = afl_paddr[31:0];
    end else if (rda) m_afsr = 0;
    if (reg_sel && reg_wr) begin
      case (reg_addr)
        12'h000: m_ctl = reg_wdata & 32'h00FF_FF83;
        12'h100: m_ctp = reg_wdata & 32'hFFFF_FFFC;
        12'h200: m_ctx = reg_wdata & ((32'd1 << CTX_W) - 1);
        default: ;
      endcase
    end
  endtask

  task automatic idle();
    flt_valid = 0; flt_level = 0; flt_access = 0; flt_type = 0; flt_addr_ok = 0;
    flt_addr = 0; flt_bus_err = 0; flt_asi = 0; afl_valid = 0; afl_uce = 0;
    afl_bto = 0; afl_berr = 0; afl_paddr = 0; reg_sel = 0; reg_wr = 0;
    reg_addr = 0; reg_wdata = 0;
  endtask

  task automatic cyc(input string tag);
    #1;
    if (reg_sel && !reg_wr) check(tag, reg_rdata, m_read(reg_addr));
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R9 trap", {31'd0, trap_req}, {31'd0, m_trap});
    idle();
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    reg_sel = 1; reg_wr = 0; reg_addr = a; cyc(tag);
  endtask

  task automatic wrr(input logic [11:0] a, input logic [31:0] d, input string tag);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d; cyc(tag);
  endtask

  task automatic flt(input logic [1:0] l, input logic [2:0] ac, input logic [2:0] ty,
                     input logic ok, input logic [31:0] ad, input logic [7:0] be,
                     input logic [7:0] asi);
    flt_valid = 1; flt_level = l; flt_access = ac; flt_type = ty; flt_addr_ok = ok;
    flt_addr = ad; flt_bus_err = be; flt_asi = asi;
  endtask

  task automatic rand_op();
    int k;
    if ($urandom_range(0, 9) < 3)
      flt($urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
          ($urandom_range(0, 1) == 1) ? 8'h09 : 8'($urandom));
    if ($urandom_range(0, 9) == 0) begin
      afl_valid = 1; afl_uce = $urandom; afl_bto = $urandom; afl_berr = $urandom;
      afl_paddr = {4'($urandom), 32'($urandom)};
    end
    if ($urandom_range(0, 9) < 4) begin
      k = $urandom_range(0, 8);
      reg_sel = 1; reg_wr = $urandom; reg_wdata = $urandom;
      reg_addr = (k < 7) ? 12'(k << 8) : ((k == 7) ? 12'h700 : 12'h304);
    end
    cyc("R12 random");
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    idle();
    m_ctl = 0; m_ctp = 0; m_ctx = 0; m_fsr = 0; m_far = 0; m_afsr = 0; m_afar = 0;
    m_full = 0; m_trap = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1 trap reset", {31'd0, trap_req}, 32'd0);
    for (int a = 0; a < 7; a++) rd(12'(a << 8), "R1 reset value");

    wrr(12'h000, 32'hFFFF_FFFF, "R2"); rd(12'h000, "R2 control");
    wrr(12'h100, 32'hFFFF_FFFF, "R3"); rd(12'h100, "R3 table pointer");
    wrr(12'h200, 32'hFFFF_FFFF, "R3"); rd(12'h200, "R3 context");
    wrr(12'h000, 32'h0000_0001, "R2");

    flt(2'd3, 3'd5, 3'd2, 1'b1, 32'hDEAD_BEE0, 8'hA5, 8'h0B); cyc("R4");
    rd(12'h300, "R4 status layout"); rd(12'h400, "R4 address");
    rd(12'h300, "R7 cleared after read");

    flt(2'd1, 3'd2, 3'd4, 1'b0, 32'h1234_5678, 8'h00, 8'h20); cyc("R5");
    rd(12'h400, "R5 address held");

    flt(2'd2, 3'd7, 3'd6, 1'b1, 32'h0000_1000, 8'h3C, 8'h20); cyc("R6");
    rd(12'h300, "R6 overwrite set");
    rd(12'h300, "R7 overwrite cleared");

    flt(2'd0, 3'd1, 3'd1, 1'b1, 32'h0000_2000, 8'h01, 8'h20); cyc("R8");
    flt(2'd1, 3'd4, 3'd3, 1'b1, 32'h0000_3000, 8'h02, 8'h20);
    reg_sel = 1; reg_wr = 0; reg_addr = 12'h300; cyc("R8 read returns old");
    rd(12'h300, "R8 event wins, no overwrite");

    wrr(12'h000, 32'h0000_0002, "R9 set no-fault");
    flt(2'd1, 3'd0, 3'd1, 1'b1, 32'h0000_4000, 8'h00, 8'h08); cyc("R9 no trap");
    rd(12'h300, "R9 still captured");
    flt(2'd1, 3'd0, 3'd1, 1'b1, 32'h0000_5000, 8'h00, 8'h09); cyc("R9 asi 9 traps");
    wrr(12'h000, 32'h0000_0000, "R9 clear no-fault");
    flt(2'd1, 3'd0, 3'd1, 1'b1, 32'h0000_6000, 8'h00, 8'h08); cyc("R9 trap");

    afl_valid = 1; afl_uce = 1; afl_bto = 0; afl_berr = 1; afl_paddr = 36'hA_CAFE_F00D;
    cyc("R10");
    rd(12'h500, "R10 async status"); rd(12'h600, "R10 async address");
    rd(12'h500, "R10 async cleared"); rd(12'h600, "R10 async address kept");

    wrr(12'h300, 32'hFFFF_FFFF, "R11"); wrr(12'h400, 32'hFFFF_FFFF, "R11");
    wrr(12'h500, 32'hFFFF_FFFF, "R11"); wrr(12'h600, 32'hFFFF_FFFF, "R11");
    rd(12'h300, "R11 status unwritten"); rd(12'h400, "R11 address unwritten");
    rd(12'h500, "R11 async unwritten"); rd(12'h600, "R11 async address unwritten");
    rd(12'h700, "R11 unmapped"); rd(12'h304, "R11 unmapped");

    repeat (4000) rand_op();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule